// File: doc/BRIEF.md
# Radar Pulse-Repetition and Timing-Window Generator

This block produces the pulse repetition trigger of a pulsed radar, and nine programmable timing windows that hang off each trigger. Every quantity is counted in cycles of the block clock, which is the divided reference clock (one cycle is 16 ns at 62.5 MHz). The trigger comes from one of three sources. An internal repetition counter, an external trigger input or a single-shot request can each start a period. Each trigger is also mirrored by an output that changes state on every pulse.

Each window has a delay, counted from the trigger cycle, and a width. Four windows drive the acquisition-sync outputs. The other five drive the transmit blanking, the transmit-amplifier blanking, the two receiver blankings and a spare output. A simple write port loads the period, delay and width values into staging registers. The whole set moves into the working registers at the next trigger, so a period never runs on a mix of old and new settings.

Top module: `radar_timing_gen`

## Requirements
- R1: After reset, `prf_o`, `prf_tog_o` and every window output are low, the working period is `RST_PERIOD` cycles (62,500 by default, a 1 kHz rate), all delays and widths are zero, and no window output rises before the first trigger pulse.
- R2: With `single_sel_i` and `ext_sel_i` low, `prf_o` is a one-cycle pulse every P cycles, where P is the working period and values below 2 act as 2. After reset release, the first pulse is high in the cycle that follows the P-th rising clock edge.
- R3: A write (`cfg_wr_i` high at a rising edge) only updates a staging register. The staged values become working values at the edge that raises `prf_o`, so they govern the cycle in which `prf_o` is high and the cycles after it. A write has no effect on the period that is already running.
- R4: Phase 0 is the cycle in which `prf_o` is high. Window k with delay D and width W is high in the cycles with phase D through D+W-1.
- R5: A window whose working width is 0 stays low.
- R6: A window that is still open when the next trigger arrives is cut off there. If its delay is nonzero it is low in the new trigger cycle, and it opens again at its delay.
- R7: `prf_tog_o` changes state in every cycle in which `prf_o` is high, and only then.
- R8: With `ext_sel_i` high and `single_sel_i` low, `prf_o` is high in the cycle after the first rising edge that samples `ext_prf_i` high following a low sample. The internal counter produces no pulse in this mode.
- R9: With `single_sel_i` high, each low-to-high change of `shot_i` gives exactly one pulse, with the same timing as in R8. The pulse does not repeat, and `ext_prf_i` is ignored whatever the state of `ext_sel_i`.
- R10: Address map. Address 0 holds the period. Address 1+k holds the delay of window k and address 16+k holds its width, for k = 0..8. Windows 0 to 3 drive `acq_sync_o[0..3]`. Windows 4, 5, 6, 7 and 8 drive `tx_blank_o`, `txamp_blank_o`, `rx1_blank_o`, `rx2_blank_o` and `spare_o` in that order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divided reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr_i | input | 1 | Write strobe for the staging registers |
| cfg_addr_i | input | 5 | Staging register address |
| cfg_data_i | input | 16 | Write data, in clock cycles |
| single_sel_i | input | 1 | High selects single-shot operation |
| ext_sel_i | input | 1 | High selects the external trigger input |
| ext_prf_i | input | 1 | External trigger input |
| shot_i | input | 1 | Debounced single-shot request |
| prf_o | output | 1 | One-cycle trigger pulse |
| prf_tog_o | output | 1 | Changes state on every trigger |
| acq_sync_o | output | 4 | Acquisition-sync windows 0 to 3 |
| tx_blank_o | output | 1 | Transmit blanking window |
| txamp_blank_o | output | 1 | Transmit-amplifier blanking window |
| rx1_blank_o | output | 1 | First receiver blanking window |
| rx2_blank_o | output | 1 | Second receiver blanking window |
| spare_o | output | 1 | Spare window |

## Verification
The bench checks the first trigger after reset at exactly 62,500 cycles, even though a shorter period has already been written. A design that applied writes at once would fire early. Window edges are sampled one cycle either side of delay and delay+width. An off-by-one in the phase origin would move every edge, and a wrong address decode would light the wrong output. A window that runs past the next trigger must drop in the trigger cycle, and a design without truncation would hold it high. A mid-period width change must not cut the window that is already open.

The mode tests cover three cases:
- External trigger and single-shot mode must each give one pulse per rising input, with no pulse from the internal counter. A level-sensitive design would give a burst.
- In single-shot mode the external input must be ignored.
- A period of 1 must repeat every 2 cycles, where a design without the clamp would fire every cycle.

// File: rtl/radar_timing_pkg.sv
// Package radar_timing_pkg
// Shared constants and the trigger source type of the radar timing generator.
// Assumes that all counts are in cycles of the divided reference clock.
package radar_timing_pkg;

    localparam int CNT_W         = 16;
    localparam int CFG_ADDR_W    = 5;
    localparam int NUM_ACQ_WIN   = 4;
    localparam int NUM_RADAR_WIN = 5;
    localparam int NUM_WIN       = NUM_ACQ_WIN + NUM_RADAR_WIN;

    // Register map: the period at 0, delays from 1, widths from 16
    localparam int ADDR_PERIOD   = 0;
    localparam int ADDR_DLY_BASE = 1;
    localparam int ADDR_WID_BASE = 16;

    localparam int MIN_PERIOD    = 2;
    localparam int DEF_PERIOD    = 62500;

    // Position of each radar window after the acquisition-sync group
    localparam int RAD_TX    = 0;
    localparam int RAD_TXAMP = 1;
    localparam int RAD_RX1   = 2;
    localparam int RAD_RX2   = 3;
    localparam int RAD_SPARE = 4;

    typedef enum logic [1:0] {
        SRC_INTERNAL = 2'd0,
        SRC_EXTERNAL = 2'd1,
        SRC_SINGLE   = 2'd2
    } trig_src_e;

endpackage

// File: rtl/radar_cfg_shadow.sv
// Module radar_cfg_shadow
// Staging and working registers for the period and the window settings.
// A write lands in the staging copy only. The working copy is reloaded
// as a whole when load_i is high, so a running period sees one consistent set.
// Assumes that load_i is the one-cycle trigger decision of the trigger unit.
module radar_cfg_shadow #(
    parameter int CNT_W      = 16,
    parameter int NUM_WIN    = 9,
    parameter int ADDR_W     = 5,
    parameter int RST_PERIOD = 62500,
    parameter int PER_ADDR   = 0,
    parameter int DLY_BASE   = 1,
    parameter int WID_BASE   = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en_i,
    input  logic [ADDR_W-1:0]               wr_addr_i,
    input  logic [CNT_W-1:0]                wr_data_i,
    input  logic                            load_i,
    output logic [CNT_W-1:0]                act_period_o,
    output logic [NUM_WIN-1:0][CNT_W-1:0]   act_dly_o,
    output logic [NUM_WIN-1:0][CNT_W-1:0]   act_wid_o
);

    localparam logic [CNT_W-1:0]  PER_RST = CNT_W'(RST_PERIOD);
    localparam logic [ADDR_W-1:0] A_PER   = ADDR_W'(PER_ADDR);

    logic [CNT_W-1:0] stg_period_q;
    logic [CNT_W-1:0] act_period_q;

    // Capture a period write into the staging register
    always_ff @(posedge clk) begin
        if (!rst_n)
            stg_period_q <= PER_RST;
        else if (wr_en_i && wr_addr_i == A_PER)
            stg_period_q <= wr_data_i;
    end

    // Move the staged period into the working register at a trigger
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_period_q <= PER_RST;
        else if (load_i)
            act_period_q <= stg_period_q;
    end

    assign act_period_o = act_period_q;

    p_shadow_period_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(act_period_o));

    for (genvar k = 0; k < NUM_WIN; k++) begin : g_slot
        localparam logic [ADDR_W-1:0] A_DLY = ADDR_W'(DLY_BASE + k);
        localparam logic [ADDR_W-1:0] A_WID = ADDR_W'(WID_BASE + k);

        logic [CNT_W-1:0] stg_dly_q, stg_wid_q;
        logic [CNT_W-1:0] act_dly_q, act_wid_q;

        // Capture delay and width writes for this window
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg_dly_q <= '0;
                stg_wid_q <= '0;
            end else if (wr_en_i) begin
                if (wr_addr_i == A_DLY) stg_dly_q <= wr_data_i;
                if (wr_addr_i == A_WID) stg_wid_q <= wr_data_i;
            end
        end

        // Move the staged window settings into the working registers at a trigger
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_dly_q <= '0;
                act_wid_q <= '0;
            end else if (load_i) begin
                act_dly_q <= stg_dly_q;
                act_wid_q <= stg_wid_q;
            end
        end

        assign act_dly_o[k] = act_dly_q;
        assign act_wid_o[k] = act_wid_q;

        p_shadow_window_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !load_i |=> ($stable(act_dly_o[k]) && $stable(act_wid_o[k])));
    end

endmodule

// File: rtl/radar_prf_trigger.sv
// Module radar_prf_trigger
// Picks the trigger source, decides when a trigger happens and keeps
// the phase counter, which counts cycles since the last trigger.
// The internal source fires once the phase reaches period-1. The
// external and single-shot sources fire on a registered rising edge.
// Assumes that shot_i is already debounced and that ext_prf_i is synchronous.
module radar_prf_trigger
    import radar_timing_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int MIN_PER = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             single_sel_i,
    input  logic             ext_sel_i,
    input  logic             ext_prf_i,
    input  logic             shot_i,
    input  logic [CNT_W-1:0] period_i,
    output logic             fire_o,
    output logic             prf_o,
    output logic             prf_tog_o,
    output logic             armed_o,
    output logic [CNT_W-1:0] phase_o
);

    localparam logic [CNT_W-1:0] MIN_P     = CNT_W'(MIN_PER);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
    localparam logic [CNT_W-1:0] PHASE_MAX = '1;

    trig_src_e        src;
    logic [CNT_W-1:0] per_eff;
    logic             ext_q, shot_q;
    logic             fire;
    logic [CNT_W-1:0] phase_q;
    logic             prf_q, tog_q, armed_q;

    // Work out the trigger source; single-shot overrides the external input
    always_comb begin
        if (single_sel_i)   src = SRC_SINGLE;
        else if (ext_sel_i) src = SRC_EXTERNAL;
        else                src = SRC_INTERNAL;
    end

    // Raise short periods to the minimum so that pulses never merge
    always_comb per_eff = (period_i < MIN_P) ? MIN_P : period_i;

    // Decide this cycle whether a trigger happens
    always_comb begin
        unique case (src)
            SRC_SINGLE:   fire = shot_i & ~shot_q;
            SRC_EXTERNAL: fire = ext_prf_i & ~ext_q;
            default:      fire = (phase_q >= per_eff - ONE);
        endcase
    end

    // Register the previous input levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q  <= 1'b0;
            shot_q <= 1'b0;
        end else begin
            ext_q  <= ext_prf_i;
            shot_q <= shot_i;
        end
    end

    // Reset the phase at a trigger, otherwise count up and saturate
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (fire)
            phase_q <= '0;
        else if (phase_q != PHASE_MAX)
            phase_q <= phase_q + ONE;
    end

    // Register the trigger pulse, its toggled copy and the first-trigger flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prf_q   <= 1'b0;
            tog_q   <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            prf_q   <= fire;
            tog_q   <= tog_q ^ fire;
            armed_q <= armed_q | fire;
        end
    end

    assign fire_o    = fire;
    assign prf_o     = prf_q;
    assign prf_tog_o = tog_q;
    assign armed_o   = armed_q;
    assign phase_o   = phase_q;

    p_internal_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (prf_o && src == SRC_INTERNAL) |=> !prf_o);

    p_tog_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prf_o |-> (prf_tog_o != $past(prf_tog_o)));

    p_tog_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !prf_o |-> $stable(prf_tog_o));

    p_ext_needs_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sel_i && !single_sel_i && !ext_prf_i) |=> !prf_o);

    p_single_needs_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (single_sel_i && !shot_i) |=> !prf_o);

endmodule

// File: rtl/radar_window_slot.sv
// Module radar_window_slot
// One timing window, open while the phase lies in [delay, delay+width).
// It stays closed until the first trigger after reset, and when the width is zero.
// Assumes that the phase restarts at 0 in the trigger cycle. That restart
// also cuts off a window that runs past the next trigger.
module radar_window_slot #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prf_i,
    input  logic             armed_i,
    input  logic [CNT_W-1:0] phase_i,
    input  logic [CNT_W-1:0] dly_i,
    input  logic [CNT_W-1:0] wid_i,
    output logic             win_o
);

    logic [CNT_W:0] end_pt;
    logic           in_range;

    // Compute the exclusive end point one bit wider so the sum cannot wrap
    always_comb end_pt = {1'b0, dly_i} + {1'b0, wid_i};

    // Compare the phase against the window bounds
    always_comb in_range = (phase_i >= dly_i) && ({1'b0, phase_i} < end_pt);

    assign win_o = armed_i && (wid_i != '0) && in_range;

    p_truncate_at_prf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (prf_i && dly_i != '0) |-> !win_o);

    p_open_at_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_o) |-> (phase_i == dly_i));

endmodule

// File: rtl/radar_timing_gen.sv
// Module radar_timing_gen
// Top level of the radar trigger and timing-window generator. It ties the
// configuration shadow, the trigger unit and one slot per window to the
// named acquisition-sync and radar outputs.
// Assumes a single clock domain, the divided reference clock.
module radar_timing_gen
    import radar_timing_pkg::*;
#(
    parameter int RST_PERIOD = DEF_PERIOD
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr_i,
    input  logic [CFG_ADDR_W-1:0]  cfg_addr_i,
    input  logic [CNT_W-1:0]       cfg_data_i,
    input  logic                   single_sel_i,
    input  logic                   ext_sel_i,
    input  logic                   ext_prf_i,
    input  logic                   shot_i,
    output logic                   prf_o,
    output logic                   prf_tog_o,
    output logic [NUM_ACQ_WIN-1:0] acq_sync_o,
    output logic                   tx_blank_o,
    output logic                   txamp_blank_o,
    output logic                   rx1_blank_o,
    output logic                   rx2_blank_o,
    output logic                   spare_o
);

    logic                          fire;
    logic                          armed;
    logic [CNT_W-1:0]              phase;
    logic [CNT_W-1:0]              act_period;
    logic [NUM_WIN-1:0][CNT_W-1:0] act_dly;
    logic [NUM_WIN-1:0][CNT_W-1:0] act_wid;
    logic [NUM_WIN-1:0]            win;

    radar_cfg_shadow #(
        .CNT_W      (CNT_W),
        .NUM_WIN    (NUM_WIN),
        .ADDR_W     (CFG_ADDR_W),
        .RST_PERIOD (RST_PERIOD),
        .PER_ADDR   (ADDR_PERIOD),
        .DLY_BASE   (ADDR_DLY_BASE),
        .WID_BASE   (ADDR_WID_BASE)
    ) i_shadow (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (cfg_wr_i),
        .wr_addr_i    (cfg_addr_i),
        .wr_data_i    (cfg_data_i),
        .load_i       (fire),
        .act_period_o (act_period),
        .act_dly_o    (act_dly),
        .act_wid_o    (act_wid)
    );

    radar_prf_trigger #(
        .CNT_W   (CNT_W),
        .MIN_PER (MIN_PERIOD)
    ) i_trigger (
        .clk          (clk),
        .rst_n        (rst_n),
        .single_sel_i (single_sel_i),
        .ext_sel_i    (ext_sel_i),
        .ext_prf_i    (ext_prf_i),
        .shot_i       (shot_i),
        .period_i     (act_period),
        .fire_o       (fire),
        .prf_o        (prf_o),
        .prf_tog_o    (prf_tog_o),
        .armed_o      (armed),
        .phase_o      (phase)
    );

    for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
        radar_window_slot #(
            .CNT_W (CNT_W)
        ) i_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .prf_i   (prf_o),
            .armed_i (armed),
            .phase_i (phase),
            .dly_i   (act_dly[k]),
            .wid_i   (act_wid[k]),
            .win_o   (win[k])
        );
    end

    // Route the windows to the named outputs; R10 fixes this order
    assign acq_sync_o    = win[NUM_ACQ_WIN-1:0];
    assign tx_blank_o    = win[NUM_ACQ_WIN + RAD_TX];
    assign txamp_blank_o = win[NUM_ACQ_WIN + RAD_TXAMP];
    assign rx1_blank_o   = win[NUM_ACQ_WIN + RAD_RX1];
    assign rx2_blank_o   = win[NUM_ACQ_WIN + RAD_RX2];
    assign spare_o       = win[NUM_ACQ_WIN + RAD_SPARE];

endmodule

// File: tb/test_radar_timing_gen.sv
// Scoreboard bench. The stimulus pushes expected trigger cycles into a queue,
// and a monitor pops each one when a pulse appears. Window edges are checked
// at computed cycles. cyc counts rising edges since reset release.
module test_radar_timing_gen;

    localparam int CLK_PERIOD = 16;
    localparam int WATCHDOG   = 70000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [15:0] cfg_data = '0;
    logic        single_sel = 1'b0;
    logic        ext_sel = 1'b0;
    logic        ext_prf = 1'b0;
    logic        shot = 1'b0;

    logic        prf, tog, tx, txamp, rx1, rx2, spare;
    logic [3:0]  acq;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit exp_tog = 1'b0;
    int exp_q[$];

    radar_timing_gen i_radar_timing_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_wr_i      (cfg_wr),
        .cfg_addr_i    (cfg_addr),
        .cfg_data_i    (cfg_data),
        .single_sel_i  (single_sel),
        .ext_sel_i     (ext_sel),
        .ext_prf_i     (ext_prf),
        .shot_i        (shot),
        .prf_o         (prf),
        .prf_tog_o     (tog),
        .acq_sync_o    (acq),
        .tx_blank_o    (tx),
        .txamp_blank_o (txamp),
        .rx1_blank_o   (rx1),
        .rx2_blank_o   (rx2),
        .spare_o       (spare)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic int win_at(input int k);
        case (k)
            0, 1, 2, 3: return int'(acq[k]);
            4:          return int'(tx);
            5:          return int'(txamp);
            6:          return int'(rx1);
            7:          return int'(rx2);
            default:    return int'(spare);
        endcase
    endfunction

    task automatic wait_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic chk_win(input int t, input int k, input int e, input string req);
        wait_cyc(t);
        check(req, win_at(k), e);
    endtask

    task automatic cfg_write(input int a, input int d);
        cfg_wr   = 1'b1;
        cfg_addr = 5'(a);
        cfg_data = 16'(d);
        @(negedge clk);
        cfg_wr   = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Monitor: pop and compare each trigger pulse; track the toggled copy
    always @(negedge clk) begin
        if (rst_n && !done && prf) begin
            int e;
            exp_tog = !exp_tog;
            if (exp_q.size() == 0) begin
                check("unexpected PRF (R2 R8 R9)", cyc, -1);
            end else begin
                e = exp_q.pop_front();
                check("PRF cycle (R2 R8 R9)", cyc, e);
            end
            check("R7 toggle follows PRF", int'(tog), int'(exp_tog));
        end
    end

    // Watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 prf in reset", int'(prf), 0);
        check("R1 toggle in reset", int'(tog), 0);
        for (int k = 0; k < 9; k++) check("R1 window in reset", win_at(k), 0);
        rst_n = 1'b1;

        // Staged during the default 62500-cycle period (R3, R10)
        cfg_write(0, 40);
        cfg_write(1 + 0, 0);  cfg_write(16 + 0, 5);
        cfg_write(1 + 1, 3);  cfg_write(16 + 1, 4);
        cfg_write(1 + 4, 10); cfg_write(16 + 4, 8);
        cfg_write(1 + 6, 30); cfg_write(16 + 6, 20);
        cfg_write(1 + 8, 5);  cfg_write(16 + 8, 0);
        exp_q.push_back(62500);
        exp_q.push_back(62540);
        exp_q.push_back(62580);
        exp_q.push_back(62620);
        exp_q.push_back(62645);
        exp_q.push_back(62670);

        wait_cyc(100);
        for (int k = 0; k < 9; k++) check("R1 no window before first PRF", win_at(k), 0);

        // Trigger at 62500, with the new settings in force
        chk_win(62500, 0, 1, "R4 acq0 opens at delay 0");
        chk_win(62500, 1, 0, "R4 acq1 closed at phase 0");
        chk_win(62502, 1, 0, "R4 acq1 closed before delay");
        chk_win(62503, 1, 1, "R4 acq1 opens at delay");
        chk_win(62504, 0, 1, "R4 acq0 last cycle");
        chk_win(62505, 0, 0, "R4 acq0 closes after width");
        chk_win(62505, 8, 0, "R5 spare with zero width");
        chk_win(62506, 1, 1, "R4 acq1 last cycle");
        chk_win(62507, 1, 0, "R4 acq1 closes");
        chk_win(62509, 4, 0, "R10 tx before delay");
        chk_win(62510, 4, 1, "R10 tx window at address 5/20");
        chk_win(62510, 5, 0, "R10 txamp untouched");
        chk_win(62517, 4, 1, "R4 tx last cycle");
        chk_win(62518, 4, 0, "R4 tx closes");
        chk_win(62529, 6, 0, "R4 rx1 before delay");
        chk_win(62530, 6, 1, "R4 rx1 opens");
        chk_win(62539, 6, 1, "R6 rx1 still open before next PRF");
        chk_win(62540, 6, 0, "R6 rx1 cut off at next PRF");
        chk_win(62570, 6, 1, "R6 rx1 reopens at delay");

        // Mid-period write must not disturb the running period (R3)
        wait_cyc(62581);
        cfg_write(16 + 0, 0);
        chk_win(62583, 0, 1, "R3 acq0 unchanged after write");
        chk_win(62584, 0, 1, "R3 acq0 keeps old width");
        chk_win(62585, 0, 0, "R3 acq0 closes at old width");
        wait_cyc(62590);
        cfg_write(0, 25);
        chk_win(62620, 0, 0, "R5 acq0 off once width 0 applies");

        // External trigger source (R8)
        wait_cyc(62671);
        ext_sel = 1'b1;
        wait_cyc(62680);
        ext_prf = 1'b1; exp_q.push_back(62681);
        wait_cyc(62684);
        ext_prf = 1'b0;
        wait_cyc(62695);
        check("R8 internal counter silent", int'(prf), 0);
        wait_cyc(62700);
        ext_prf = 1'b1; exp_q.push_back(62701);
        wait_cyc(62702);
        ext_prf = 1'b0;

        // Single shot with priority over the external input (R9)
        wait_cyc(62800);
        single_sel = 1'b1;
        wait_cyc(62805);
        ext_prf = 1'b1;
        wait_cyc(62806);
        check("R9 external input ignored in single-shot", int'(prf), 0);
        wait_cyc(62808);
        ext_prf = 1'b0;
        wait_cyc(62810);
        cfg_write(0, 1);
        wait_cyc(62815);
        shot = 1'b1; exp_q.push_back(62816);

        // Period 1 acts as 2 (R2)
        wait_cyc(62816);
        single_sel = 1'b0;
        ext_sel    = 1'b0;
        exp_q.push_back(62818);
        exp_q.push_back(62820);
        exp_q.push_back(62822);
        wait_cyc(62822);
        single_sel = 1'b1;
        wait_cyc(62823);
        shot = 1'b0;
        wait_cyc(62830);
        shot = 1'b1; exp_q.push_back(62831);
        wait_cyc(62835);
        shot = 1'b0;

        wait_cyc(62900);
        check("R2 R8 R9 no missing PRF", exp_q.size(), 0);
        finish_run();
    end

endmodule